// File: doc/BRIEF.md
# Indirect Per-Channel Settings Access Controller

This block gives a host processor access to a table of per-channel transceiver settings, such as output swing and pre-emphasis pre-tap, through a small register window. The host does not address a setting directly. It selects a logical channel and a feature offset, loads or collects a value in a data register, and starts the transfer with a command bit. It then polls a busy flag until the back end has finished.

The back end is a settings store with a fixed access latency of `LATENCY` cycles. A sequencer state machine runs each access. Its states are `ST_IDLE`, `ST_WAIT_WR`, `ST_WAIT_RD`, `ST_COMMIT_WR` and `ST_COMMIT_RD`. An accepted write command moves it from `ST_IDLE` to `ST_WAIT_WR`, and an accepted read command moves it from `ST_IDLE` to `ST_WAIT_RD`. Each wait state counts down and then moves to its commit state. Both commit states return to `ST_IDLE` after one cycle. The store is written, or the data register is loaded, on that final transition.

While the sequencer is in any state other than `ST_IDLE`, busy is high and the window registers are frozen. Commands that arrive while busy is high, and commands that address a channel or offset outside the table, are rejected and raise a sticky error flag.

Top module: `chan_cfg_window`

## Requirements
- R1: The window has four word addresses: channel select at 0x8, control/status at 0xA, feature offset at 0xB and data at 0xC. Channel and offset each keep the low 8 bits written, and data keeps the low 8 bits. A read returns the register zero-extended. A read of any other address returns 0, and `host_rdata` is 0 whenever `host_rd` is low.
- R2: After reset, every stored setting is 0, busy is low, the error flag is low, and all window registers read 0.
- R3: Writing control with bit 0 or bit 1 set, while idle and in range, raises busy (control bit 8) on that same clock edge. Busy stays high for exactly `LATENCY` (8) cycles.
- R4: A write command (control bit 0) stores the data register into the entry for the selected channel and offset when busy falls. No other entry changes. Offset 0 is output swing and offset 1 is pre-emphasis pre-tap.
- R5: A read command (control bit 1) loads the data register from the selected entry on the edge where busy falls. If bits 0 and 1 are written together, the write command takes effect and the data register is not reloaded.
- R6: Command bits 0 and 1 always read back as 0.
- R7: While busy is high, writes to the channel, offset and data registers are ignored.
- R8: A command written while busy is high is dropped, and the error flag (control bit 9) is set.
- R9: The error flag stays set until control is written with bit 9 equal to 1, and that write clears it.
- R10: A command whose channel is 4 or above, or whose offset is 4 or above, sets the error flag. It does not raise busy and leaves both the store and the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W (4) | Word address of the window register |
| host_wr | input | 1 | Write strobe, sampled on the clock edge |
| host_rd | input | 1 | Read strobe; read data is combinational |
| host_wdata | input | DATA_W (32) | Write data |
| host_rdata | output | DATA_W (32) | Read data, 0 when not reading |

## Verification
The bench uses the default build: 4 channels, 4 offsets, 8-bit values and an 8-cycle latency. With these values the whole busy window can be polled cycle by cycle. The bench reads the data register one cycle before the read command completes and again one cycle after, so the cycle of the load is pinned down. The 4x4 table has power-of-two index widths, so a channel value of 4 truncates onto channel 0. A write of 4 therefore exposes any missing range check as a corruption of channel 0's output swing entry.

// File: rtl/chan_cfg_pkg.sv
package chan_cfg_pkg;

    // Sequencer states for one back-end access
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_WR,
        ST_WAIT_RD,
        ST_COMMIT_WR,
        ST_COMMIT_RD
    } seq_state_t;

    // Window word addresses (host software depends on these)
    localparam int unsigned ADDR_CHAN = 8;
    localparam int unsigned ADDR_CTRL = 10;
    localparam int unsigned ADDR_FEAT = 11;
    localparam int unsigned ADDR_DATA = 12;

    // Control/status bit positions
    localparam int BIT_CMD_WR = 0;
    localparam int BIT_CMD_RD = 1;
    localparam int BIT_BUSY   = 8;
    localparam int BIT_ERR    = 9;

endpackage

// File: rtl/chan_cfg_window_store.sv
module chan_cfg_window_store #(
    parameter int NUM_CH   = 4,
    parameter int NUM_FEAT = 4,
    parameter int VAL_W    = 8,
    parameter int CH_W     = 2,
    parameter int FT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CH_W-1:0]  ch_sel,
    input  logic [FT_W-1:0]  ft_sel,
    input  logic [VAL_W-1:0] wval,
    output logic [VAL_W-1:0] rval
);

    logic [VAL_W-1:0] cells [NUM_CH][NUM_FEAT];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar f = 0; f < NUM_FEAT; f++) begin : g_ft
            logic hit;
            assign hit = we && (ch_sel == CH_W'(c)) && (ft_sel == FT_W'(f));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cells[c][f] <= '0;
                end else if (hit) begin
                    cells[c][f] <= wval;
                end
            end
        end
    end

    assign rval = cells[ch_sel][ft_sel];

endmodule

// File: rtl/chan_cfg_window_seq.sv
module chan_cfg_window_seq
    import chan_cfg_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_rd,
    output logic busy,
    output logic store_we,
    output logic load_data
);

    localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LATENCY - 2);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr) begin
                    state_d = ST_WAIT_WR;
                    cnt_d   = CNT_INIT;
                end else if (start_rd) begin
                    state_d = ST_WAIT_RD;
                    cnt_d   = CNT_INIT;
                end
            end
            ST_WAIT_WR: begin
                if (cnt_q == '0) state_d = ST_COMMIT_WR;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_WAIT_RD: begin
                if (cnt_q == '0) state_d = ST_COMMIT_RD;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_COMMIT_WR: state_d = ST_IDLE;
            ST_COMMIT_RD: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b1;
        store_we  = 1'b0;
        load_data = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy      = 1'b0;
            ST_WAIT_WR:   busy      = 1'b1;
            ST_WAIT_RD:   busy      = 1'b1;
            ST_COMMIT_WR: store_we  = 1'b1;
            ST_COMMIT_RD: load_data = 1'b1;
            default:      busy      = 1'b0;
        endcase
    end

endmodule

// File: rtl/chan_cfg_window_regs.sv
module chan_cfg_window_regs
    import chan_cfg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int FIELD_W  = 8,
    parameter int VAL_W    = 8,
    parameter int NUM_CH   = 4,
    parameter int NUM_FEAT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               busy,
    input  logic               load_data,
    input  logic [VAL_W-1:0]   load_val,
    output logic [FIELD_W-1:0] ch_reg,
    output logic [FIELD_W-1:0] ft_reg,
    output logic [VAL_W-1:0]   data_reg,
    output logic               start_wr,
    output logic               start_rd,
    output logic               err
);

    localparam logic [ADDR_W-1:0] A_CHAN = ADDR_W'(ADDR_CHAN);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'(ADDR_FEAT);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);

    logic wr_chan, wr_ctrl, wr_feat, wr_data;
    logic cmd_wr_bit, cmd_rd_bit, cmd_any, in_range;
    logic err_set, err_clr;
    logic unused_wdata;

    assign wr_chan = host_wr && (host_addr == A_CHAN);
    assign wr_ctrl = host_wr && (host_addr == A_CTRL);
    assign wr_feat = host_wr && (host_addr == A_FEAT);
    assign wr_data = host_wr && (host_addr == A_DATA);

    assign cmd_wr_bit = host_wdata[BIT_CMD_WR];
    assign cmd_rd_bit = host_wdata[BIT_CMD_RD];
    assign cmd_any    = wr_ctrl && (cmd_wr_bit || cmd_rd_bit);

    assign in_range = (ch_reg < FIELD_W'(NUM_CH)) && (ft_reg < FIELD_W'(NUM_FEAT));

    assign start_wr = cmd_any && !busy && in_range && cmd_wr_bit;
    assign start_rd = cmd_any && !busy && in_range && !cmd_wr_bit;
    assign err_set  = cmd_any && (busy || !in_range);
    assign err_clr  = wr_ctrl && host_wdata[BIT_ERR];

    assign unused_wdata = ^host_wdata;

    // Window registers; frozen while an access runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_reg   <= '0;
            ft_reg   <= '0;
            data_reg <= '0;
            err      <= 1'b0;
        end else begin
            if (wr_chan && !busy) ch_reg <= host_wdata[FIELD_W-1:0];
            if (wr_feat && !busy) ft_reg <= host_wdata[FIELD_W-1:0];
            if (load_data) begin
                data_reg <= load_val;
            end else if (wr_data && !busy) begin
                data_reg <= host_wdata[VAL_W-1:0];
            end
            if (err_set)      err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    // Read mux
    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (host_addr)
                A_CHAN: host_rdata[FIELD_W-1:0] = ch_reg;
                A_FEAT: host_rdata[FIELD_W-1:0] = ft_reg;
                A_DATA: host_rdata[VAL_W-1:0]   = data_reg;
                A_CTRL: begin
                    host_rdata[BIT_BUSY] = busy;
                    host_rdata[BIT_ERR]  = err;
                end
                default: host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/chan_cfg_window.sv
module chan_cfg_window #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int FIELD_W  = 8,
    parameter int VAL_W    = 8,
    parameter int NUM_CH   = 4,
    parameter int NUM_FEAT = 4,
    parameter int LATENCY  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int FT_W = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1;

    logic [FIELD_W-1:0] ch_reg, ft_reg;
    logic [VAL_W-1:0]   data_reg, store_rval;
    logic               start_wr, start_rd, err_bit;
    logic               seq_busy, store_we, load_data;

    chan_cfg_window_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .FIELD_W (FIELD_W),
        .VAL_W   (VAL_W),
        .NUM_CH  (NUM_CH),
        .NUM_FEAT(NUM_FEAT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .busy      (seq_busy),
        .load_data (load_data),
        .load_val  (store_rval),
        .ch_reg    (ch_reg),
        .ft_reg    (ft_reg),
        .data_reg  (data_reg),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .err       (err_bit)
    );

    chan_cfg_window_seq #(
        .LATENCY(LATENCY)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .busy     (seq_busy),
        .store_we (store_we),
        .load_data(load_data)
    );

    chan_cfg_window_store #(
        .NUM_CH  (NUM_CH),
        .NUM_FEAT(NUM_FEAT),
        .VAL_W   (VAL_W),
        .CH_W    (CH_W),
        .FT_W    (FT_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .ch_sel(ch_reg[CH_W-1:0]),
        .ft_sel(ft_reg[FT_W-1:0]),
        .wval  (data_reg),
        .rval  (store_rval)
    );

endmodule

// File: rtl/chan_cfg_window_chk.sv
module chan_cfg_window_chk
    import chan_cfg_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 8,
    parameter int LATENCY = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  host_addr,
    input logic               host_wr,
    input logic               host_rd,
    input logic [DATA_W-1:0]  host_wdata,
    input logic [DATA_W-1:0]  host_rdata,
    input logic               busy,
    input logic               err,
    input logic [FIELD_W-1:0] ch_reg,
    input logic [FIELD_W-1:0] ft_reg
);

    int unsigned busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    logic is_ctrl_wr, is_cmd_wr;
    assign is_ctrl_wr = host_wr && (host_addr == ADDR_W'(ADDR_CTRL));
    assign is_cmd_wr  = is_ctrl_wr && (host_wdata[BIT_CMD_WR] || host_wdata[BIT_CMD_RD]);

    // R1
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> host_rdata == '0);

    // R6
    cmd_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_W'(ADDR_CTRL)) |-> host_rdata[1:0] == 2'b00);

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(is_cmd_wr));

    // R3
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt == LATENCY);

    // R7
    chan_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_addr == ADDR_W'(ADDR_CHAN)) |=> $stable(ch_reg));

    // R7
    feat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_addr == ADDR_W'(ADDR_FEAT)) |=> $stable(ft_reg));

    // R8
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_cmd_wr) |=> err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(is_ctrl_wr && host_wdata[BIT_ERR])) |=> err);

endmodule

bind chan_cfg_window chan_cfg_window_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FIELD_W(FIELD_W),
    .LATENCY(LATENCY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy      (seq_busy),
    .err       (err_bit),
    .ch_reg    (ch_reg),
    .ft_reg    (ft_reg)
);

// File: tb/test_chan_cfg_window.sv
module test_chan_cfg_window;

    localparam logic [3:0] A_CHAN = 4'h8;
    localparam logic [3:0] A_CTRL = 4'hA;
    localparam logic [3:0] A_FEAT = 4'hB;
    localparam logic [3:0] A_DATA = 4'hC;
    localparam logic [31:0] ST_BUSY = 32'h100;
    localparam logic [31:0] ST_ERR  = 32'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    chan_cfg_window i_chan_cfg_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // Monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        if (host_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (host_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", t, host_rdata, e);
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(posedge clk);
        #1;
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string t);
        host_addr = a;
        host_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk);
        #1;
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R2: reset state
        rd_chk(A_CHAN, 32'h0, "R2 chan after reset");
        rd_chk(A_CTRL, 32'h0, "R2 ctrl after reset");
        rd_chk(A_FEAT, 32'h0, "R2 feat after reset");
        rd_chk(A_DATA, 32'h0, "R2 data after reset");
        // R1: unmapped address
        rd_chk(4'h3, 32'h0, "R1 unmapped read");

        // R1: window readback
        wr_reg(A_CHAN, 32'hFFFF_FF02);
        rd_chk(A_CHAN, 32'h02, "R1 chan readback");
        wr_reg(A_CHAN, 32'h0);
        wr_reg(A_FEAT, 32'h0);
        wr_reg(A_DATA, 32'h1234_5628);
        rd_chk(A_DATA, 32'h28, "R1 data readback");

        // R3/R6: write channel 0 swing = 0x28, busy window
        wr_reg(A_CTRL, 32'h1);
        rd_chk(A_CTRL, ST_BUSY, "R3 R6 busy first cycle");
        idle(6);
        rd_chk(A_CTRL, ST_BUSY, "R3 busy last cycle");
        rd_chk(A_CTRL, 32'h0, "R3 busy cleared");

        // R7/R8: frozen window and dropped command
        wr_reg(A_CHAN, 32'h1);
        wr_reg(A_FEAT, 32'h1);
        wr_reg(A_DATA, 32'h5A);
        wr_reg(A_CTRL, 32'h1);
        wr_reg(A_CHAN, 32'h3);
        wr_reg(A_FEAT, 32'h2);
        wr_reg(A_DATA, 32'hFF);
        wr_reg(A_CTRL, 32'h2);
        rd_chk(A_CTRL, ST_BUSY | ST_ERR, "R8 err while busy");
        idle(3);
        rd_chk(A_CHAN, 32'h1, "R7 chan ignored");
        rd_chk(A_FEAT, 32'h1, "R7 feat ignored");
        rd_chk(A_DATA, 32'h5A, "R7 data ignored");
        rd_chk(A_CTRL, ST_ERR, "R8 err held");

        // R9: sticky, write-1-to-clear
        wr_reg(A_CTRL, 32'h0);
        rd_chk(A_CTRL, ST_ERR, "R9 err sticky");
        wr_reg(A_CTRL, ST_ERR);
        rd_chk(A_CTRL, 32'h0, "R9 err cleared");

        // R4/R5: read back channel 0 swing
        wr_reg(A_CHAN, 32'h0);
        wr_reg(A_FEAT, 32'h0);
        wr_reg(A_DATA, 32'h0);
        wr_reg(A_CTRL, 32'h2);
        idle(7);
        rd_chk(A_DATA, 32'h0, "R5 data not yet loaded");
        rd_chk(A_DATA, 32'h28, "R4 R5 ch0 swing");

        wr_reg(A_CHAN, 32'h1);
        wr_reg(A_FEAT, 32'h1);
        wr_reg(A_CTRL, 32'h2);
        idle(8);
        rd_chk(A_DATA, 32'h5A, "R4 ch1 pretap");

        wr_reg(A_CHAN, 32'h3);
        wr_reg(A_FEAT, 32'h3);
        wr_reg(A_CTRL, 32'h2);
        idle(8);
        rd_chk(A_DATA, 32'h0, "R2 untouched entry zero");

        // R10: out-of-range channel
        wr_reg(A_CHAN, 32'h4);
        wr_reg(A_FEAT, 32'h0);
        wr_reg(A_DATA, 32'h77);
        wr_reg(A_CTRL, 32'h1);
        rd_chk(A_CTRL, ST_ERR, "R10 bad chan no busy");
        wr_reg(A_CTRL, ST_ERR);
        wr_reg(A_CHAN, 32'h0);
        wr_reg(A_CTRL, 32'h2);
        idle(8);
        rd_chk(A_DATA, 32'h28, "R10 store unchanged");

        // R10: out-of-range offset on a read
        wr_reg(A_CHAN, 32'h2);
        wr_reg(A_FEAT, 32'h5);
        wr_reg(A_DATA, 32'h66);
        wr_reg(A_CTRL, 32'h2);
        rd_chk(A_CTRL, ST_ERR, "R10 bad offset err");
        rd_chk(A_DATA, 32'h66, "R10 data unchanged");
        wr_reg(A_CTRL, ST_ERR);

        // R5: both command bits -> write wins
        wr_reg(A_FEAT, 32'h1);
        wr_reg(A_DATA, 32'h3C);
        wr_reg(A_CTRL, 32'h3);
        idle(8);
        rd_chk(A_CTRL, 32'h0, "R5 both bits done");
        rd_chk(A_DATA, 32'h3C, "R5 data not reloaded");
        wr_reg(A_DATA, 32'h0);
        wr_reg(A_CTRL, 32'h2);
        idle(8);
        rd_chk(A_DATA, 32'h3C, "R5 write took effect");

        // R4: neighbouring entry untouched
        wr_reg(A_FEAT, 32'h0);
        wr_reg(A_CTRL, 32'h2);
        idle(8);
        rd_chk(A_DATA, 32'h0, "R4 neighbour untouched");

        idle(2);
        done = 1'b1;
        finish_run();
    end

endmodule